// File: doc/BRIEF.md
# OTG Wrapper Interrupt Register Block

This block is a small memory-mapped register set placed next to a USB3 controller core. It watches four OTG control outputs of the core: VBUS drive, VBUS charge, VBUS discharge and ID pull-up. Each rising edge and each falling edge of these signals sets its own sticky status bit. A level OTG event input, a core interrupt input, and the clearing of a DMA-disable configuration bit also set sticky status bits. The status bits are grouped onto two interrupt lines. Each line has a raw view, a masked view, and a pair of write-one-to-set and write-one-to-clear enable registers. An end-of-interrupt register briefly drops a line so that an edge-sensitive interrupt controller sees a fresh edge.

A software-mode override lets firmware take over the five OTG status signals presented to the core: power present, ID digital, session end, session valid and VBUS valid. The register port is a simple 32-bit write strobe with a combinational read. Software uses the block by enabling the events it cares about, taking the interrupt, reading the masked status, and writing the same value back to acknowledge it.

Top module: `otg_irq_regs`

## Requirements
- R1: After reset, all enables, raw status, the DMA-disable bit and the OTG status register are zero, and both interrupt outputs are low.
- R2: Register byte offsets are:
  - 0x00 revision, a read-only constant given by parameter REVISION; writes to it are ignored.
  - 0x10 configuration.
  - 0x20 end-of-interrupt.
  - 0x24, 0x28, 0x2C and 0x30: line 0 raw status, masked status, enable-set and enable-clear.
  - 0x34, 0x38, 0x3C and 0x40: the same four registers for line 1.
  - 0x80 OTG control levels.
  - 0x84 OTG status override.
  - Any other offset reads zero.
- R3: `ctl_in` bit order is [3] VBUS drive, [2] VBUS charge, [1] VBUS discharge, [0] ID pull-up.
  - After a two-flop synchronizer, a rising edge sets line 1 raw bit 13, 12, 11 or 8 respectively.
  - A falling edge sets bit 5, 4, 3 or 0 respectively.
  - The status bit is visible within four clocks of the input change.
- R4: Reading offset 0x80 returns the synchronized `ctl_in` levels at bits 5, 4, 3 and 0, in the same order as R3. All other bits read zero.
- R5: `otg_event_in` high at a clock edge sets line 1 raw bit 16. `core_irq_in` high at a clock edge sets line 0 raw bit 0.
- R6: Configuration bit 16 is DMA-disable and drives `dma_disable`. A write that changes it from 1 to 0 sets line 1 raw bit 17. A write that sets it does not set bit 17.
- R7: Writing 1s to an enable-set register sets those enable bits. Writing 1s to an enable-clear register clears them. Zero bits leave the enables unchanged. Both addresses read back the current enables, and on line 1 only bits 17, 16, 13, 12, 11, 8, 5, 4, 3 and 0 can be enabled.
- R8: Masked status reads as raw AND enable. Each interrupt output is high when any masked bit of its line is set.
- R9: Writing 1s to either the raw or the masked status address of a line clears those raw bits, and zero bits have no effect. An event arriving in the same cycle as its clear leaves the bit set.
- R10: A write to offset 0x20 forces interrupt line `wdata[0]` low for the one following cycle. The line then returns to its masked-status value.
- R11: `core_stat` and `phy_stat` use the bit order [4] power present, [3] ID digital, [2] session end, [1] session valid, [0] VBUS valid. While OTG status bit 31 is set, `core_stat` takes these from OTG status bits 9, 4, 3, 2 and 1 respectively. Otherwise `core_stat` equals `phy_stat`.
- R12: Only bits 31, 9, 4, 3, 2 and 1 of the OTG status register hold written values. Its other bits read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register byte offset for read and write |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data for `addr` |
| core_irq_in | input | 1 | Core interrupt request (line 0 source) |
| otg_event_in | input | 1 | OTG event request (line 1 bit 16) |
| ctl_in | input | 4 | Core OTG control outputs, asynchronous |
| phy_stat | input | 5 | OTG status from the PHY side |
| irq0 | output | 1 | Interrupt line 0 |
| irq1 | output | 1 | Interrupt line 1 |
| dma_disable | output | 1 | DMA-disable configuration bit |
| core_stat | output | 5 | OTG status presented to the core |

## Verification
The assertions assume that `wr_en` is low while reset is held. They also assume that `addr` and `wdata` are settled before each rising edge on which `wr_en` is high. The bench meets this by driving every register access on the falling clock edge and by keeping `wr_en` low until reset has been released. The control inputs are changed only on falling edges. Each new control pattern is held for four clocks before status is read, which leaves room for the synchronizer and the previous-value register.

// File: rtl/otg_irq_pkg.sv
package otg_irq_pkg;

    localparam int DW    = 32;
    localparam int NCTL  = 4;
    localparam int NSTAT = 5;

    // register byte offsets (software decodes these)
    localparam logic [11:0] OFF_ID     = 12'h000;
    localparam logic [11:0] OFF_CFG    = 12'h010;
    localparam logic [11:0] OFF_EOI    = 12'h020;
    localparam logic [11:0] OFF_RAW0   = 12'h024;
    localparam logic [11:0] OFF_STAT0  = 12'h028;
    localparam logic [11:0] OFF_ENSET0 = 12'h02C;
    localparam logic [11:0] OFF_ENCLR0 = 12'h030;
    localparam logic [11:0] OFF_RAW1   = 12'h034;
    localparam logic [11:0] OFF_STAT1  = 12'h038;
    localparam logic [11:0] OFF_ENSET1 = 12'h03C;
    localparam logic [11:0] OFF_ENCLR1 = 12'h040;
    localparam logic [11:0] OFF_OCTL   = 12'h080;
    localparam logic [11:0] OFF_OSTAT  = 12'h084;

    // control index -> fall bit position; rise bit sits RISE_SHIFT above
    localparam int CTL_POS [NCTL] = '{0, 3, 4, 5};
    localparam int RISE_SHIFT     = 8;

    // status index -> OTG status register bit position
    localparam int STAT_POS [NSTAT] = '{1, 2, 3, 4, 9};

    localparam int BIT_OTG_EV  = 16;
    localparam int BIT_DMA_CLR = 17;
    localparam int BIT_DMA_DIS = 16;
    localparam int BIT_SW_MODE = 31;

    localparam logic [DW-1:0] EV1_MASK   = 32'h0003_3939;
    localparam logic [DW-1:0] OSTAT_MASK = 32'h8000_021E;

    typedef struct packed {
        logic          raw0;
        logic          en0;
        logic [DW-1:0] raw1;
        logic [DW-1:0] en1;
        logic          dma_dis;
        logic [DW-1:0] ostat;
        logic [1:0]    eoi;
    } regs_t;

endpackage

// File: rtl/otg_ctl_edge.sv
module otg_ctl_edge #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] level,
    output logic [WIDTH-1:0] rise,
    output logic [WIDTH-1:0] fall
);

    typedef struct packed {
        logic [STAGES-1:0][WIDTH-1:0] sync;
        logic [WIDTH-1:0]             prev;
    } edge_t;

    edge_t e_d, e_q;

    always_comb begin
        e_d         = e_q;
        e_d.sync[0] = async_in;
        for (int i = 1; i < STAGES; i++) begin
            e_d.sync[i] = e_q.sync[i-1];
        end
        e_d.prev = e_q.sync[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) e_q <= '0;
        else        e_q <= e_d;
    end

    assign level = e_q.sync[STAGES-1];
    assign rise  = level & ~e_q.prev;
    assign fall  = ~level & e_q.prev;

endmodule

// File: rtl/otg_stat_mux.sv
module otg_stat_mux #(
    parameter int NBITS = 5
) (
    input  logic             sw_mode,
    input  logic [NBITS-1:0] reg_val,
    input  logic [NBITS-1:0] phy_val,
    output logic [NBITS-1:0] core_val
);

    for (genvar g = 0; g < NBITS; g++) begin : g_bit
        assign core_val[g] = sw_mode ? reg_val[g] : phy_val[g];
    end

endmodule

// File: rtl/otg_irq_regs.sv
module otg_irq_regs
    import otg_irq_pkg::*;
#(
    parameter int          ADDR_W   = 12,
    parameter logic [31:0] REVISION = 32'h5A3C_0100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    input  logic              core_irq_in,
    input  logic              otg_event_in,
    input  logic [3:0]        ctl_in,
    input  logic [4:0]        phy_stat,
    output logic              irq0,
    output logic              irq1,
    output logic              dma_disable,
    output logic [4:0]        core_stat
);

    localparam logic [ADDR_W-1:0] A_ID     = ADDR_W'(OFF_ID);
    localparam logic [ADDR_W-1:0] A_CFG    = ADDR_W'(OFF_CFG);
    localparam logic [ADDR_W-1:0] A_EOI    = ADDR_W'(OFF_EOI);
    localparam logic [ADDR_W-1:0] A_RAW0   = ADDR_W'(OFF_RAW0);
    localparam logic [ADDR_W-1:0] A_STAT0  = ADDR_W'(OFF_STAT0);
    localparam logic [ADDR_W-1:0] A_ENSET0 = ADDR_W'(OFF_ENSET0);
    localparam logic [ADDR_W-1:0] A_ENCLR0 = ADDR_W'(OFF_ENCLR0);
    localparam logic [ADDR_W-1:0] A_RAW1   = ADDR_W'(OFF_RAW1);
    localparam logic [ADDR_W-1:0] A_STAT1  = ADDR_W'(OFF_STAT1);
    localparam logic [ADDR_W-1:0] A_ENSET1 = ADDR_W'(OFF_ENSET1);
    localparam logic [ADDR_W-1:0] A_ENCLR1 = ADDR_W'(OFF_ENCLR1);
    localparam logic [ADDR_W-1:0] A_OCTL   = ADDR_W'(OFF_OCTL);
    localparam logic [ADDR_W-1:0] A_OSTAT  = ADDR_W'(OFF_OSTAT);

    regs_t s_d, s_q;

    logic [NCTL-1:0]  ctl_level, ctl_rise, ctl_fall;
    logic [NSTAT-1:0] sw_stat;
    logic [DW-1:0]    ev1, octl_view;
    logic             dma_fall;

    // names the bound checker observes
    logic [DW-1:0] raw1_q, en1_q;
    assign raw1_q = s_q.raw1;
    assign en1_q  = s_q.en1;

    otg_ctl_edge #(.WIDTH(NCTL), .STAGES(2)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (ctl_in),
        .level    (ctl_level),
        .rise     (ctl_rise),
        .fall     (ctl_fall)
    );

    for (genvar g = 0; g < NSTAT; g++) begin : g_sw
        assign sw_stat[g] = s_q.ostat[STAT_POS[g]];
    end

    otg_stat_mux #(.NBITS(NSTAT)) u_mux (
        .sw_mode  (s_q.ostat[BIT_SW_MODE]),
        .reg_val  (sw_stat),
        .phy_val  (phy_stat),
        .core_val (core_stat)
    );

    always_comb begin
        ev1       = '0;
        octl_view = '0;
        for (int i = 0; i < NCTL; i++) begin
            ev1[CTL_POS[i]]              = ctl_fall[i];
            ev1[CTL_POS[i] + RISE_SHIFT] = ctl_rise[i];
            octl_view[CTL_POS[i]]        = ctl_level[i];
        end
        ev1[BIT_OTG_EV] = otg_event_in;
    end

    // next-state: register writes first, new events last so they win
    always_comb begin
        s_d     = s_q;
        s_d.eoi = 2'b00;
        if (wr_en) begin
            case (addr)
                A_CFG:             s_d.dma_dis = wdata[BIT_DMA_DIS];
                A_EOI:             s_d.eoi[wdata[0]] = 1'b1;
                A_RAW0, A_STAT0:   s_d.raw0 = s_q.raw0 & ~wdata[0];
                A_ENSET0:          s_d.en0  = s_q.en0 | wdata[0];
                A_ENCLR0:          s_d.en0  = s_q.en0 & ~wdata[0];
                A_RAW1, A_STAT1:   s_d.raw1 = s_q.raw1 & ~wdata;
                A_ENSET1:          s_d.en1  = (s_q.en1 | wdata) & EV1_MASK;
                A_ENCLR1:          s_d.en1  = s_q.en1 & ~wdata;
                A_OSTAT:           s_d.ostat = wdata & OSTAT_MASK;
                default:           ;
            endcase
        end
        dma_fall = s_q.dma_dis & ~s_d.dma_dis;
        s_d.raw1 = s_d.raw1 | ev1;
        s_d.raw1[BIT_DMA_CLR] = s_d.raw1[BIT_DMA_CLR] | dma_fall;
        s_d.raw0 = s_d.raw0 | core_irq_in;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        case (addr)
            A_ID:              rdata = REVISION;
            A_CFG:             rdata = DW'(s_q.dma_dis) << BIT_DMA_DIS;
            A_RAW0:            rdata = DW'(s_q.raw0);
            A_STAT0:           rdata = DW'(s_q.raw0 & s_q.en0);
            A_ENSET0, A_ENCLR0: rdata = DW'(s_q.en0);
            A_RAW1:            rdata = s_q.raw1;
            A_STAT1:           rdata = s_q.raw1 & s_q.en1;
            A_ENSET1, A_ENCLR1: rdata = s_q.en1;
            A_OCTL:            rdata = octl_view;
            A_OSTAT:           rdata = s_q.ostat;
            default:           rdata = '0;
        endcase
    end

    assign irq0        = s_q.raw0 & s_q.en0 & ~s_q.eoi[0];
    assign irq1        = (|(s_q.raw1 & s_q.en1)) & ~s_q.eoi[1];
    assign dma_disable = s_q.dma_dis;

endmodule

// File: rtl/otg_irq_regs_chk.sv
module otg_irq_regs_chk
    import otg_irq_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [31:0]       wdata,
    input logic              irq0,
    input logic              irq1,
    input logic              dma_disable,
    input logic [31:0]       raw1,
    input logic [31:0]       en1
);

    AST_ENSET_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(OFF_ENSET1)) |=>
        ((en1 & $past(wdata) & EV1_MASK) == ($past(wdata) & EV1_MASK))); // R7

    AST_ENCLR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(OFF_ENCLR1)) |=>
        ((en1 & $past(wdata)) == '0)); // R7

    AST_RAW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && (addr == ADDR_W'(OFF_RAW1) || addr == ADDR_W'(OFF_STAT1))) |=>
        ((raw1 & $past(raw1)) == $past(raw1))); // R9

    AST_QUIET_WHEN_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (en1 == '0) |-> !irq1); // R8

    AST_DMA_CLEAR_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dma_disable) |-> raw1[BIT_DMA_CLR]); // R6

    AST_EOI_LINE1_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(OFF_EOI) && wdata[0]) |=> !irq1); // R10

    AST_EOI_LINE0_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(OFF_EOI) && !wdata[0]) |=> !irq0); // R10

endmodule

bind otg_irq_regs otg_irq_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .addr        (addr),
    .wdata       (wdata),
    .irq0        (irq0),
    .irq1        (irq1),
    .dma_disable (dma_disable),
    .raw1        (raw1_q),
    .en1         (en1_q)
);

// File: tb/test_otg_irq_regs.sv
module test_otg_irq_regs;

    localparam int          CLK_PERIOD = 10;
    localparam int          ADDR_W     = 12;
    localparam logic [31:0] REV        = 32'h5A3C_0100;

    // {ctl_in, expected line-1 raw status after the change}
    localparam int NVEC = 8;
    localparam logic [35:0] VEC [NVEC] = '{
        {4'b1000, 32'h0000_2000},
        {4'b0000, 32'h0000_0020},
        {4'b0110, 32'h0000_1800},
        {4'b0011, 32'h0000_0110},
        {4'b1111, 32'h0000_3000},
        {4'b0000, 32'h0000_0039},
        {4'b0001, 32'h0000_0100},
        {4'b1000, 32'h0000_2001}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [31:0]       wdata = '0;
    logic [31:0]       rdata;
    logic              core_irq_in = 1'b0;
    logic              otg_event_in = 1'b0;
    logic [3:0]        ctl_in = 4'b0000;
    logic [4:0]        phy_stat = 5'b00110;
    logic              irq0, irq1, dma_disable;
    logic [4:0]        core_stat;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    otg_irq_regs #(.ADDR_W(ADDR_W), .REVISION(REV)) i_otg_irq_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .addr         (addr),
        .wdata        (wdata),
        .rdata        (rdata),
        .core_irq_in  (core_irq_in),
        .otg_event_in (otg_event_in),
        .ctl_in       (ctl_in),
        .phy_stat     (phy_stat),
        .irq0         (irq0),
        .irq1         (irq1),
        .dma_disable  (dma_disable),
        .core_stat    (core_stat)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        addr  = a[ADDR_W-1:0];
        wdata = d;
        @(posedge clk);
        #1;
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a[ADDR_W-1:0];
        #1;
        d = rdata;
    endtask

    function automatic logic [31:0] octl_of(input logic [3:0] c);
        logic [31:0] v = '0;
        v[5] = c[3];
        v[4] = c[2];
        v[3] = c[1];
        v[0] = c[0];
        return v;
    endfunction

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        #1;
        check("R1 irq0", 32'(irq0), 32'h0);
        check("R1 irq1", 32'(irq1), 32'h0);
        check("R1 dma_disable", 32'(dma_disable), 32'h0);
        check("R1 core_stat from phy", 32'(core_stat), 32'h06);
        rd(12'h03C, v); check("R1 line1 enables", v, 32'h0);
        rd(12'h034, v); check("R1 line1 raw", v, 32'h0);
        rd(12'h084, v); check("R1 otg status", v, 32'h0);

        // R2 decode
        rd(12'h000, v); check("R2 revision", v, REV);
        wr(12'h000, 32'hFFFF_FFFF);
        rd(12'h000, v); check("R2 revision read-only", v, REV);
        rd(12'h050, v); check("R2 unmapped 0x50", v, 32'h0);
        rd(12'h104, v); check("R2 unmapped 0x104", v, 32'h0);

        // R3 / R4 edge table
        for (int k = 0; k < NVEC; k++) begin
            @(negedge clk);
            ctl_in = VEC[k][35:32];
            repeat (4) @(posedge clk);
            rd(12'h034, v); check("R3 edge status", v, VEC[k][31:0]);
            rd(12'h080, v); check("R4 control levels", v, octl_of(VEC[k][35:32]));
            wr(12'h034, 32'hFFFF_FFFF);
        end
        rd(12'h034, v); check("R9 raw cleared by ones", v, 32'h0);

        // R5 event inputs
        @(negedge clk); otg_event_in = 1'b1; core_irq_in = 1'b1;
        @(posedge clk); #1; otg_event_in = 1'b0; core_irq_in = 1'b0;
        rd(12'h034, v); check("R5 otg event bit16", v, 32'h0001_0000);
        rd(12'h024, v); check("R5 core irq raw0", v, 32'h1);
        rd(12'h028, v); check("R8 masked line0 disabled", v, 32'h0);
        check("R8 irq0 low when disabled", 32'(irq0), 32'h0);

        // R7 enable set/clear
        wr(12'h03C, 32'h0000_2000);
        rd(12'h03C, v); check("R7 set", v, 32'h0000_2000);
        wr(12'h03C, 32'h0000_0010);
        rd(12'h040, v); check("R7 zeros keep bits", v, 32'h0000_2010);
        wr(12'h040, 32'h0000_2000);
        rd(12'h03C, v); check("R7 clear", v, 32'h0000_0010);
        wr(12'h03C, 32'hFFFF_FFFF);
        rd(12'h03C, v); check("R7 only event bits", v, 32'h0003_3939);
        wr(12'h040, 32'hFFFF_FFFF);
        rd(12'h03C, v); check("R7 clear all", v, 32'h0);

        // R8 masking and irq1
        check("R8 irq1 low while masked", 32'(irq1), 32'h0);
        wr(12'h03C, 32'h0001_0000);
        check("R8 irq1 high", 32'(irq1), 32'h1);
        rd(12'h038, v); check("R8 masked line1", v, 32'h0001_0000);
        wr(12'h040, 32'h0001_0000);
        check("R8 irq1 low after disable", 32'(irq1), 32'h0);
        rd(12'h034, v); check("R8 raw kept", v, 32'h0001_0000);

        // R9 clearing
        wr(12'h038, 32'h0);
        rd(12'h034, v); check("R9 zero write no effect", v, 32'h0001_0000);
        @(negedge clk);
        wr_en = 1'b1; addr = 12'h034; wdata = 32'h0001_0000; otg_event_in = 1'b1;
        @(posedge clk); #1;
        wr_en = 1'b0; otg_event_in = 1'b0;
        rd(12'h034, v); check("R9 event wins over clear", v, 32'h0001_0000);
        wr(12'h038, 32'h0001_0000);
        rd(12'h034, v); check("R9 clear via masked address", v, 32'h0);

        // R10 end of interrupt on line 0
        wr(12'h02C, 32'h1);
        check("R8 irq0 high", 32'(irq0), 32'h1);
        wr(12'h020, 32'h0);
        check("R10 irq0 forced low", 32'(irq0), 32'h0);
        @(posedge clk); #1;
        check("R10 irq0 returns", 32'(irq0), 32'h1);
        wr(12'h028, 32'h1);
        check("R9 irq0 cleared", 32'(irq0), 32'h0);
        rd(12'h024, v); check("R9 raw0 cleared", v, 32'h0);

        // R6 DMA-disable clear event
        wr(12'h010, 32'h0001_0000);
        check("R6 dma_disable set", 32'(dma_disable), 32'h1);
        rd(12'h010, v); check("R6 cfg readback", v, 32'h0001_0000);
        rd(12'h034, v); check("R6 no event on set", v, 32'h0);
        wr(12'h010, 32'h0);
        rd(12'h034, v); check("R6 event on clear", v, 32'h0002_0000);
        wr(12'h034, 32'h0002_0000);

        // R11 / R12 software override
        @(negedge clk); phy_stat = 5'b10101; #1;
        check("R11 phy path", 32'(core_stat), 32'h15);
        wr(12'h084, 32'h8000_0204);
        check("R11 sw override", 32'(core_stat), 32'h12);
        wr(12'h084, 32'hFFFF_FFFF);
        rd(12'h084, v); check("R12 writable bits", v, 32'h8000_021E);
        check("R11 sw all ones", 32'(core_stat), 32'h1F);
        wr(12'h084, 32'h0000_021E);
        check("R11 back to phy", 32'(core_stat), 32'h15);

        finish_run();
    end

endmodule